// File: doc/BRIEF.md
# Consecutive-Comparison Phase Lock Monitor

This block watches the two divided pulse trains that feed a phase comparator: the divided reference and the divided oscillator. It brings both into the fast sampling-clock domain and finds their rising edges. For every pair of edges it counts the sampling cycles between them. A comparison passes when that gap is inside a programmable window.

The lock flag rises only after a parameterised number of passing comparisons in a row. Any failure clears the run and drops the flag at once. A failure is a gap at or beyond the window, or a first edge whose partner never arrives within a timeout.

A two-bit mode input selects four states. In two of them the monitor is disabled: the flag is held low and the run is cleared.

Top module: `phase_lock_monitor`

## Requirements
- R1: After reset the lock flag is low and the run of passing comparisons is empty, so a full run of NEED_CNT passes is needed before lock.
- R2: A comparison passes when the gap between the reference rising edge and the oscillator rising edge is less than WIN_CYC sampling cycles. The gap is measured from whichever edge comes first, and coincident edges have a gap of 0. A gap of exactly WIN_CYC fails.
- R3: The lock flag stays low after NEED_CNT-1 consecutive passes and goes high after the NEED_CNT-th pass.
- R4: A failing comparison clears the run and drops the lock flag.
- R5: An edge on one input with no rising edge on the other within TIMEOUT_CYC sampling cycles counts as a failing comparison.
- R6: The run counter saturates at NEED_CNT and does not wrap, so lock stays high through any number of further passes.
- R7: The mode input encodes 2'b00 = active, low pump current; 2'b01 = mid-supply, disabled; 2'b10 = open, disabled; 2'b11 = active, high pump current. While disabled the lock flag is low and the run is cleared, so after re-enabling NEED_CNT fresh passes are needed.
- R8: Both pulse inputs pass through SYNC_STAGES flip-flops before edge detection. Only a low-to-high transition starts or completes a comparison, so an input held high produces no further edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | Divided reference pulse (asynchronous) |
| osc_pulse_i | input | 1 | Divided oscillator pulse (asynchronous) |
| mode_i | input | 2 | Control mode, encoding per R7 |
| lock_o | output | 1 | Lock flag |

## Verification
Each signed gap from -20 to +20 cycles is applied after a run of coincident comparisons. This separates the pass side of the window from the fail side at both leads, including the WIN_CYC-1 and WIN_CYC boundary, and shows whether a failure clears a saturated run. Single-sided frames with either input alone exercise the timeout. A pulse held high across two frames shows that a level, unlike an edge, cannot satisfy a comparison. Runs of six, seven and twelve passes, with each disabled mode inserted between them, separate the lock threshold, saturation and clearing by mode.

// File: rtl/lock_mon_pkg.sv
package lock_mon_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_OSC = 2'd1,
    ST_WAIT_REF = 2'd2
  } meas_state_t;

  // mode 01 (mid-supply) and 10 (open) disable the monitor
  function automatic logic mode_active(input logic [1:0] mode);
    return (mode == 2'b00) || (mode == 2'b11);
  endfunction

endpackage

// File: rtl/pulse_sync.sv
module pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES:0] chain;
  logic            prev_q;

  assign chain[0] = async_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g+1] <= 1'b0;
      else         chain[g+1] <= chain[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain[STAGES];
  end

  assign rise_o = chain[STAGES] & ~prev_q;

  // R8: a rising edge is a single-cycle event
  p_rise_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/phase_gap_meas.sv
module phase_gap_meas
  import lock_mon_pkg::*;
#(
  parameter int WIN_CYC     = 25,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ref_rise_i,
  input  logic osc_rise_i,
  output logic done_o,
  output logic pass_o
);

  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] WIN_L = CW'(WIN_CYC);
  localparam logic [CW-1:0] TMO_L = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] ONE_L = CW'(1);

  meas_state_t   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d, pass_q, pass_d;
  logic          partner, leader;

  assign partner = (state_q == ST_WAIT_OSC) ? osc_rise_i : ref_rise_i;
  assign leader  = (state_q == ST_WAIT_OSC) ? ref_rise_i : osc_rise_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    pass_d  = 1'b0;
    if (clr_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (state_q == ST_IDLE) begin
      if (ref_rise_i && osc_rise_i) begin
        done_d = 1'b1;
        pass_d = 1'b1;
      end else if (ref_rise_i) begin
        state_d = ST_WAIT_OSC;
        cnt_d   = ONE_L;
      end else if (osc_rise_i) begin
        state_d = ST_WAIT_REF;
        cnt_d   = ONE_L;
      end
    end else begin
      if (partner) begin
        done_d  = 1'b1;
        pass_d  = (cnt_q < WIN_L);
        state_d = ST_IDLE;
        cnt_d   = '0;
      end else if (leader) begin
        // second leader edge without partner: fail, restart from it
        done_d = 1'b1;
        cnt_d  = ONE_L;
      end else if (cnt_q >= TMO_L) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + ONE_L;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      pass_q  <= pass_d;
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;

  // R5: the gap counter never runs past the timeout
  p_gap_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (cnt_q <= TMO_L));

  // R2: coincident edges yield a passing comparison
  p_coincident_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && ref_rise_i && osc_rise_i && !clr_i) |=> (done_o && pass_o));

  // R7: no result while held clear
  p_clr_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !done_o);

endmodule

// File: rtl/consec_counter.sv
module consec_counter #(
  parameter int NEED_CNT = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic done_i,
  input  logic pass_i,
  output logic lock_o
);

  localparam int CW = $clog2(NEED_CNT + 1);
  localparam logic [CW-1:0] NEED_L = CW'(NEED_CNT);
  localparam logic [CW-1:0] ONE_L  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lock_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)                cnt_d = '0;
    else if (done_i && !pass_i) cnt_d = '0;
    else if (done_i && cnt_q != NEED_L) cnt_d = cnt_q + ONE_L;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= en_i && (cnt_d == NEED_L);
    end
  end

  assign lock_o = lock_q;

  // R6: run count never exceeds its ceiling
  p_cnt_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= NEED_L);

  // R4: a failed comparison drops lock
  p_fail_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !pass_i) |=> !lock_o);

  // R3: lock only rises on a passing comparison
  p_rise_on_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(done_i && pass_i));

  // R7: disabled mode forces lock low
  p_disabled_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !lock_o);

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
  import lock_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_CYC     = 25,
  parameter int TIMEOUT_CYC = 256,
  parameter int NEED_CNT    = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_pulse_i,
  input  logic       osc_pulse_i,
  input  logic [1:0] mode_i,
  output logic       lock_o
);

  localparam int NCH = 2;

  logic [NCH-1:0] pulse_raw, pulse_rise;
  logic           active, done, pass;

  assign pulse_raw = {osc_pulse_i, ref_pulse_i};
  assign active    = mode_active(mode_i);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(pulse_raw[c]),
      .rise_o (pulse_rise[c])
    );
  end

  phase_gap_meas #(
    .WIN_CYC    (WIN_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_meas (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (~active),
    .ref_rise_i(pulse_rise[0]),
    .osc_rise_i(pulse_rise[1]),
    .done_o    (done),
    .pass_o    (pass)
  );

  consec_counter #(.NEED_CNT(NEED_CNT)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (active),
    .done_i(done),
    .pass_i(pass),
    .lock_o(lock_o)
  );

endmodule

// File: tb/tb_phase_lock_monitor.sv
module tb_phase_lock_monitor;

  localparam int WIN  = 8;
  localparam int TMO  = 40;
  localparam int NEED = 7;
  localparam int FR   = 60;
  localparam int K_NONE = 0, K_CMP = 1, K_FAIL = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_p = 1'b0, osc_p = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       lock;

  int n_vec = 0, n_bad = 0, m_cnt = 0;

  always #4 clk = ~clk;

  phase_lock_monitor #(
    .SYNC_STAGES(2), .WIN_CYC(WIN), .TIMEOUT_CYC(TMO), .NEED_CNT(NEED)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_pulse_i(ref_p),
    .osc_pulse_i(osc_p), .mode_i(mode), .lock_o(lock)
  );

  task automatic check(input string tag, input logic exp);
    n_vec++;
    if (lock !== exp) begin
      n_bad++;
      $display("FAIL %s: lock_o actual %b expected %b (t=%0t)", tag, lock, exp, $time);
    end
  endtask

  // tr/to: rise cycle of ref/osc within frame, -1 = absent; hold keeps osc high
  task automatic frame(input int tr, input int to, input bit hold, input int kind,
                       input string tag);
    bit en, ok;
    for (int c = 0; c < FR; c++) begin
      @(negedge clk);
      ref_p = (tr >= 0 && c >= tr && c < tr + 3);
      osc_p = hold || (to >= 0 && c >= to && c < to + 3);
    end
    en = (mode == 2'b00) || (mode == 2'b11);
    ok = (kind == K_CMP) && ((tr > to ? tr - to : to - tr) < WIN);
    if (!en) m_cnt = 0;
    else if (kind != K_NONE) m_cnt = ok ? ((m_cnt < NEED) ? m_cnt + 1 : NEED) : 0;
    check(tag, en && (m_cnt == NEED));
  endtask

  task automatic gap(input int d, input string tag);
    if (d >= 0) frame(0, d, 1'b0, K_CMP, tag);
    else        frame(-d, 0, 1'b0, K_CMP, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual not finished, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", 1'b0);

    // R3 threshold: six passes low, seventh high
    for (int k = 0; k < NEED; k++) gap(0, "R3 run");
    // R6 saturation: keep passing well beyond the ceiling
    for (int k = 0; k < 12; k++) gap(k % WIN, "R6 saturated");

    // R2/R4 sweep of signed gaps, each after a fresh run
    for (int d = -20; d <= 20; d++) begin
      for (int k = 0; k < NEED; k++) gap(0, "R3 prime");
      gap(d, ((d < 0 ? -d : d) < WIN) ? "R2 in window" : "R4 out of window");
    end

    // R5 missing partner on either side
    for (int k = 0; k < NEED; k++) gap(0, "R3 prime");
    frame(0, -1, 1'b0, K_FAIL, "R5 ref alone");
    for (int k = 0; k < NEED; k++) gap(1, "R3 prime");
    frame(-1, 0, 1'b0, K_FAIL, "R5 osc alone");

    // R8 held level is not an edge
    for (int k = 0; k < NEED; k++) gap(0, "R3 prime");
    frame(0, 0, 1'b1, K_CMP, "R8 rising osc");
    frame(0, -1, 1'b1, K_FAIL, "R8 held osc");
    frame(-1, -1, 1'b0, K_NONE, "R8 release");

    // R7 disabled modes clear the run; active modes both work
    for (int m = 1; m <= 2; m++) begin
      mode = 2'b11;
      for (int k = 0; k < NEED; k++) gap(2, "R7 active 11");
      mode = m[1:0];
      gap(0, "R7 disabled");
      gap(0, "R7 disabled");
      mode = 2'b00;
      for (int k = 0; k < NEED; k++) gap(0, "R7 re-enabled");
    end

    // R1 reset mid-lock clears the run
    rst_n = 1'b0;
    @(negedge clk);
    m_cnt = 0;
    check("R1 reset while locked", 1'b0);
    rst_n = 1'b1;
    for (int k = 0; k < NEED; k++) gap(-3, "R1 fresh run");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule